// File: doc/BRIEF.md
# External Edge Interrupt and DMA Request Unit

This block watches a handful of external pad inputs and turns selected signal transitions into service requests. Each pad first passes through a two-flop synchronizer. The block then compares the synchronized value with its value one clock earlier. A rising or falling transition whose type software has enabled for that channel sets a sticky status flag. The flag stays set until software writes a one to it or a DMA engine acknowledges the channel.

A per-channel request enable decides whether a set flag raises a request at all. A per-channel routing bit then steers the request either to a single shared interrupt line or to that channel's own DMA request line. Only channels 0, 1, 2, 3, 5 and 10 are built. The other channel positions in every register word are reserved.

Software reaches the block through a single-cycle register port with a 32-bit data bus. Read data is combinational while `req_i` is high.

Top module: `edge_req_unit`

## Requirements
- R1: After reset, all five registers read zero, `irq_o` is 0 and `dma_req_o` is all zeros.
- R2: Writing 1 to a status bit clears that channel's flag. Writing 0 leaves the flag unchanged. Status bits that are written with 1 while their flag is clear stay clear.
- R3: A flag sets at the third rising clock edge after its pad changes, provided the transition direction is enabled in the rising-edge enable register or the falling-edge enable register. The two enables are independent, and both may be 1 at once.
- R4: A flag sets whatever the request-enable bit holds. While the enable bit is 0, the channel drives neither `irq_o` nor its `dma_req_o` bit.
- R5: Routing bit value 0 sends an enabled, set flag to `irq_o`, which is the OR over all channels. Routing bit value 1 sends it to `dma_req_o[c]` only.
- R6: A one-cycle pulse on `dma_ack_i[c]` clears flag c.
- R7: When a new transition and a clear (a write of 1 or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: The register offsets are: status 0x10, request enable 0x18, routing 0x20, rising-edge enable 0x28 and falling-edge enable 0x30. Channel c sits at data bit 31-c. The built channels are 0, 1, 2, 3, 5 and 10.
- R9: Reserved bit positions read 0 and ignore writes; writing all ones to a register reads back 0xF4200000. A transition on the pad of an unbuilt channel never sets a flag.
- R10: `rdata_o` shows the register addressed while `req_i` is high and `we_i` is low. It reads 0 for an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pad_i | input | 11 | Asynchronous pad inputs, one per channel index |
| dma_ack_i | input | 11 | Per-channel DMA acknowledge, clears the flag |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | 11 | Per-channel DMA request |

## Verification
A vector table drives pads with all-rising, all-falling, mixed-direction and wrong-direction transitions under different edge-enable masks. This shows the direction decode, the independence of the two enables, and that unbuilt channel positions stay silent. Directed sequences then pit a clear against a new transition in the same cycle. They also compare writing 0 with writing 1 to the status register. Finally they walk one flag through enable-off, interrupt-routed, DMA-routed and acknowledged states, which separates the gating, steering and acknowledge paths.

// File: rtl/edge_req_pkg.sv
package edge_req_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL   = 8'h30;

  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } route_e;
endpackage

// File: rtl/edge_req_detect.sv
module edge_req_detect #(
  parameter int unsigned          NUM_CH      = 11,
  parameter logic [NUM_CH-1:0]    CH_MASK     = '1,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pad_i,
  input  logic [NUM_CH-1:0] rise_en_i,
  input  logic [NUM_CH-1:0] fall_en_i,
  output logic [NUM_CH-1:0] edge_hit_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (CH_MASK[c]) begin : g_impl
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   prev_q;
      logic                   cur;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i[c]};
          prev_q <= sync_q[SYNC_STAGES-1];
        end
      end

      assign cur           = sync_q[SYNC_STAGES-1];
      assign edge_hit_o[c] = (rise_en_i[c] &  cur & ~prev_q)
                           | (fall_en_i[c] & ~cur &  prev_q);
    end else begin : g_void
      assign edge_hit_o[c] = 1'b0;
    end
  end

  logic unused_in;
  assign unused_in = ^{pad_i & ~CH_MASK, rise_en_i & ~CH_MASK, fall_en_i & ~CH_MASK};

endmodule

// File: rtl/edge_req_regs.sv
module edge_req_regs
  import edge_req_pkg::*;
#(
  parameter int unsigned       NUM_CH  = 11,
  parameter logic [NUM_CH-1:0] CH_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] edge_hit_i,
  input  logic [NUM_CH-1:0] dma_ack_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] route_o,
  output logic [NUM_CH-1:0] rise_o,
  output logic [NUM_CH-1:0] fall_o
);

  logic              wr;
  logic              wr_status, wr_enable, wr_route, wr_rise, wr_fall;
  logic [NUM_CH-1:0] wr_ch;
  logic [NUM_CH-1:0] rd_vec;
  logic [REG_W-1:0]  rd_word;

  assign wr        = req_i & we_i;
  assign wr_status = wr & (addr_i == OFS_STATUS);
  assign wr_enable = wr & (addr_i == OFS_ENABLE);
  assign wr_route  = wr & (addr_i == OFS_ROUTE);
  assign wr_rise   = wr & (addr_i == OFS_RISE);
  assign wr_fall   = wr & (addr_i == OFS_FALL);

  // channel c lives at bit REG_W-1-c
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) wr_ch[c] = wdata_i[REG_W-1-c];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (CH_MASK[c]) begin : g_impl
      logic flag_q, en_q, route_q, rise_q, fall_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q  <= 1'b0;
          en_q    <= 1'b0;
          route_q <= 1'b0;
          rise_q  <= 1'b0;
          fall_q  <= 1'b0;
        end else begin
          // new edge beats any clear in the same cycle
          flag_q <= edge_hit_i[c]
                  | (flag_q & ~(wr_status & wr_ch[c]) & ~dma_ack_i[c]);
          if (wr_enable) en_q    <= wr_ch[c];
          if (wr_route)  route_q <= wr_ch[c];
          if (wr_rise)   rise_q  <= wr_ch[c];
          if (wr_fall)   fall_q  <= wr_ch[c];
        end
      end

      assign flag_o[c]  = flag_q;
      assign en_o[c]    = en_q;
      assign route_o[c] = route_q;
      assign rise_o[c]  = rise_q;
      assign fall_o[c]  = fall_q;
    end else begin : g_void
      assign flag_o[c]  = 1'b0;
      assign en_o[c]    = 1'b0;
      assign route_o[c] = 1'b0;
      assign rise_o[c]  = 1'b0;
      assign fall_o[c]  = 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_STATUS: rd_vec = flag_o;
      OFS_ENABLE: rd_vec = en_o;
      OFS_ROUTE:  rd_vec = route_o;
      OFS_RISE:   rd_vec = rise_o;
      OFS_FALL:   rd_vec = fall_o;
      default:    rd_vec = '0;
    endcase
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) rd_word[REG_W-1-c] = rd_vec[c];
  end

  assign rdata_o = (req_i && !we_i) ? rd_word : '0;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[REG_W-1-NUM_CH:0], wr_ch & ~CH_MASK,
                         edge_hit_i & ~CH_MASK, dma_ack_i & ~CH_MASK};

endmodule

// File: rtl/edge_req_route.sv
module edge_req_route
  import edge_req_pkg::*;
#(
  parameter int unsigned NUM_CH = 11
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] route_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_req_o
);

  logic [NUM_CH-1:0] irq_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic live;
    assign live         = flag_i[c] & en_i[c];
    assign irq_vec[c]   = live & (route_e'(route_i[c]) == ROUTE_IRQ);
    assign dma_req_o[c] = live & (route_e'(route_i[c]) == ROUTE_DMA);
  end

  assign irq_o = |irq_vec;

endmodule

// File: rtl/edge_req_unit.sv
module edge_req_unit
  import edge_req_pkg::*;
#(
  parameter int unsigned       NUM_CH  = 11,
  parameter logic [NUM_CH-1:0] CH_MASK = 11'h42F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] pad_i,
  input  logic [NUM_CH-1:0] dma_ack_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] dma_req_o
);

  logic [NUM_CH-1:0] edge_hit;
  logic [NUM_CH-1:0] flag_q, en_q, route_q, rise_q, fall_q;

  edge_req_detect #(
    .NUM_CH      (NUM_CH),
    .CH_MASK     (CH_MASK),
    .SYNC_STAGES (2)
  ) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pad_i      (pad_i),
    .rise_en_i  (rise_q),
    .fall_en_i  (fall_q),
    .edge_hit_o (edge_hit)
  );

  edge_req_regs #(
    .NUM_CH  (NUM_CH),
    .CH_MASK (CH_MASK)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .edge_hit_i (edge_hit),
    .dma_ack_i  (dma_ack_i),
    .flag_o     (flag_q),
    .en_o       (en_q),
    .route_o    (route_q),
    .rise_o     (rise_q),
    .fall_o     (fall_q)
  );

  edge_req_route #(
    .NUM_CH (NUM_CH)
  ) u_route (
    .flag_i    (flag_q),
    .en_i      (en_q),
    .route_i   (route_q),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

endmodule

// File: rtl/edge_req_unit_chk.sv
module edge_req_unit_chk
  import edge_req_pkg::*;
#(
  parameter int unsigned       NUM_CH  = 11,
  parameter logic [NUM_CH-1:0] CH_MASK = 11'h42F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [NUM_CH-1:0] dma_ack_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] dma_req_o,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] edge_hit
);

  logic [NUM_CH-1:0] clr_mask;
  logic [REG_W-1:0]  impl_word;

  always_comb begin
    impl_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      clr_mask[c] = req_i & we_i & (addr_i == OFS_STATUS) & wdata_i[REG_W-1-c];
      impl_word[REG_W-1-c] = CH_MASK[c];
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_q) & ~$past(clr_mask) & ~$past(dma_ack_i) & ~flag_q) == '0); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0); // R3

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(edge_hit) & ~flag_q) == '0); // R7

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!irq_o && dma_req_o == '0)); // R4

  AST_DMA_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~(flag_q & en_q)) == '0); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dma_ack_i) & ~$past(edge_hit) & flag_q) == '0); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~impl_word) == '0); // R9

  AST_UNBUILT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~CH_MASK) == '0); // R9

  AST_READ_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0)); // R10

endmodule

bind edge_req_unit edge_req_unit_chk #(
  .NUM_CH  (NUM_CH),
  .CH_MASK (CH_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .dma_ack_i (dma_ack_i),
  .irq_o     (irq_o),
  .dma_req_o (dma_req_o),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .edge_hit  (edge_hit)
);

// File: tb/edge_req_unit_test.sv
`timescale 1ns/1ps
module edge_req_unit_test;
  localparam int unsigned NCH = 11;
  localparam logic [7:0] A_STATUS = 8'h10, A_ENABLE = 8'h18, A_ROUTE = 8'h20,
                         A_RISE = 8'h28, A_FALL = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pad = '0, ack = '0;
  logic irq;
  logic [NCH-1:0] dreq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  edge_req_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .dma_ack_i(ack),
    .irq_o(irq), .dma_req_o(dreq)
  );

  typedef struct packed {
    logic [NCH-1:0] rise;
    logic [NCH-1:0] fall;
    logic [NCH-1:0] from;
    logic [NCH-1:0] to;
    logic [NCH-1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{11'h7FF, 11'h000, 11'h000, 11'h7FF, 11'h42F},
    '{11'h000, 11'h7FF, 11'h7FF, 11'h000, 11'h42F},
    '{11'h7FF, 11'h000, 11'h7FF, 11'h000, 11'h000},
    '{11'h00F, 11'h420, 11'h000, 11'h7FF, 11'h00F},
    '{11'h00F, 11'h420, 11'h7FF, 11'h000, 11'h420},
    '{11'h42F, 11'h42F, 11'h005, 11'h420, 11'h425},
    '{11'h002, 11'h008, 11'h00A, 11'h000, 11'h008},
    '{11'h0D0, 11'h0D0, 11'h000, 11'h7FF, 11'h000}
  };

  function automatic logic [31:0] to_reg(logic [NCH-1:0] m);
    logic [31:0] r = '0;
    for (int c = 0; c < NCH; c++) if (m[c]) r[31-c] = 1'b1;
    return r;
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STATUS, d); check("R1 status", d, 32'h0);
    rd(A_ENABLE, d); check("R1 enable", d, 32'h0);
    rd(A_ROUTE, d);  check("R1 route", d, 32'h0);
    rd(A_RISE, d);   check("R1 rise", d, 32'h0);
    rd(A_FALL, d);   check("R1 fall", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dma", {21'b0, dreq}, 32'h0);

    // R8 R9 register map and reserved bits
    wr(A_ENABLE, 32'hFFFF_FFFF);
    rd(A_ENABLE, d); check("R9 R8 enable mask", d, 32'hF420_0000);
    wr(A_ENABLE, 32'h0);
    wr(A_ROUTE, 32'hFFFF_FFFF);
    rd(A_ROUTE, d);  check("R9 route mask", d, 32'hF420_0000);
    wr(A_ROUTE, 32'h0);
    rd(8'h14, d);    check("R10 unmapped", d, 32'h0);

    // table: R3 edge decode, R9 unbuilt pads, R4 no request while disabled
    for (int i = 0; i < 8; i++) begin
      wr(A_RISE, to_reg(VECS[i].rise));
      wr(A_FALL, to_reg(VECS[i].fall));
      @(negedge clk); pad = VECS[i].from;
      repeat (4) @(negedge clk);
      wr(A_STATUS, 32'hFFFF_FFFF);
      @(negedge clk); pad = VECS[i].to;
      repeat (3) @(posedge clk);
      rd(A_STATUS, d);
      check($sformatf("R3 R9 vec%0d", i), d, to_reg(VECS[i].exp));
      check($sformatf("R4 vec%0d req", i), {20'b0, irq, dreq}, 32'h0);
    end

    // R3 rising on ch0 and ch5
    wr(A_RISE, to_reg(11'h021));
    wr(A_FALL, 32'h0);
    @(negedge clk); pad = '0;
    repeat (4) @(negedge clk);
    wr(A_STATUS, 32'hFFFF_FFFF);
    @(negedge clk); pad = 11'h021;
    repeat (3) @(posedge clk);
    rd(A_STATUS, d); check("R3 ch0 ch5", d, 32'h8400_0000);

    // R2 write zero vs write one
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, d); check("R2 write0", d, 32'h8400_0000);
    wr(A_STATUS, 32'h8000_0000);
    rd(A_STATUS, d); check("R2 write1", d, 32'h0400_0000);

    // R4 gating, R5 routing
    check("R4 disabled", {20'b0, irq, dreq}, 32'h0);
    wr(A_ENABLE, 32'h0400_0000);
    @(negedge clk);
    check("R5 irq route", {20'b0, irq, dreq}, 32'h0000_0800);
    wr(A_ROUTE, 32'h0400_0000);
    @(negedge clk);
    check("R5 dma route", {20'b0, irq, dreq}, 32'h0000_0020);

    // R6 acknowledge
    @(negedge clk); ack = 11'h020;
    @(negedge clk); ack = '0;
    check("R6 dma low", {20'b0, irq, dreq}, 32'h0);
    rd(A_STATUS, d); check("R6 flag cleared", d, 32'h0);

    // R7 set wins over same-cycle clear
    @(negedge clk); pad = '0;
    repeat (4) @(negedge clk);
    pad[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_STATUS; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    rd(A_STATUS, d); check("R7 set wins", d, 32'h8000_0000);
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd(A_STATUS, d); check("R2 clear after", d, 32'h0);

    summary();
    $finish;
  end
endmodule